// File: doc/BRIEF.md
# Six-Channel Interval Timer Bank

This peripheral holds six independent down-counters behind a 1 KiB register window on a plain synchronous bus. Each cycle the bus can perform one write, and a read returns the addressed register in the same cycle. The counters step on a `tick_en` strobe, which stands in for the timer clock.

Each channel has its own control, interval and live-count registers. It can run in periodic mode or in one-shot mode. When a channel expires, it sets its bit in a shared status register, and that bit is cleared by writing 1. The channel also raises a one-cycle pulse on its own interrupt line, gated by a shared enable register. The clock-select field and two watchdog words are kept as storage only.

Software programs an interval, then writes control with the enable bit set (and the reload bit, if the counter must restart from the interval). It then services the status bits, either from the pulses or by polling.

Top module: `ivtimer_bank`

## Requirements
- R1: After reset, interrupt enable, interrupt status, every interval and every count read 0. Every control register reads 0x04 (clock select 2'b01 in bits [3:2], channel stopped), and `irq_o` is 0.
- R2: Channel n (0..5) owns byte addresses (n+1)*0x10 + 0x0 (control), + 0x4 (interval) and + 0x8 (count). Interrupt enable is at 0x000 and status is at 0x004, with bit n belonging to channel n. Any other address reads 0.
- R3: A write to a channel's interval register stores the value and loads it into that channel's counter on the same edge.
- R4: Control keeps bits [7:0] of the written word and reads higher bits as 0. Bit 0 is enable, bit 1 is reload, bits [3:2] are clock select (stored only) and bit 7 is mode (1 = one-shot). A control write with bit 1 set copies the interval into the counter.
- R5: An enabled channel's counter drops by one on each cycle in which `tick_en` is high. A stopped channel holds its count. A control or interval write to a channel in a cycle takes precedence, and that channel ignores the tick.
- R6: A channel expires on the tick that takes its counter from 1 to 0. Expiry sets its status bit whatever the enable bit says.
- R7: In periodic mode the channel stays enabled after expiry. A tick with the counter at 0 reloads the interval.
- R8: In one-shot mode, expiry clears the channel's control bit 0 and the counter stays at 0.
- R9: `irq_o[n]` is high for exactly the one cycle after channel n's expiry edge, and only when interrupt-enable bit n was set at that edge.
- R10: Writing status clears each bit written as 1 and leaves the bits written as 0 unchanged. An expiry in the same cycle keeps its bit set.
- R11: Writes to a count register change nothing. Addresses 0x090 and 0x094 store full 32-bit words, read them back and do not affect any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe for all channels |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 10 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_o | output | 6 | Per-channel interrupt pulses |

## Verification
The bench targets several corner cases:
- A status clear that lands on the same edge as an expiry. A design that lets the clear win would lose that interrupt.
- A control or interval write that coincides with a tick. A design that merges the two would count one step low.
- A one-shot expiry, where a design that forgot to drop the enable bit would keep reloading.
- A periodic channel sitting at zero, where a reload skipped or taken too early would stretch or shorten the period.

Disabled interrupt bits and writes to the count register, clock-select field and watchdog words are also checked. Any of these that leaked into the pulses or the counters would show up at the read port or on `irq_o`.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned RELOAD_BIT = 1;
  localparam int unsigned MODE_BIT   = 7;
  localparam logic [7:0]  CTRL_RST   = 8'h04;

  localparam int unsigned OFS_IEN  = 'h000;
  localparam int unsigned OFS_STAT = 'h004;
  localparam int unsigned OFS_WD0  = 'h090;
  localparam int unsigned OFS_WD1  = 'h094;

  typedef enum logic [1:0] {SUB_CTRL, SUB_INTV, SUB_CNT, SUB_NONE} sub_e;

  function automatic sub_e decode_sub(input logic [3:0] lo);
    case (lo)
      4'h0:    return SUB_CTRL;
      4'h4:    return SUB_INTV;
      4'h8:    return SUB_CNT;
      default: return SUB_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctrl_we,
  input  logic             intv_we,
  input  logic [CNT_W-1:0] wr_val,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] intv_q, cnt_q;
  logic             run, at_one, at_zero;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] iv,
                                                  input logic oneshot);
    if (c == '0) return oneshot ? c : iv;
    return c - CNT_W'(1);
  endfunction

  assign run      = tick_en && ctrl_q[EN_BIT] && !ctrl_we && !intv_we;
  assign at_one   = (cnt_q == CNT_W'(1));
  assign at_zero  = (cnt_q == '0);
  assign expire_o = run && at_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      intv_q <= '0;
      cnt_q  <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wr_val[7:0];
      if (wr_val[RELOAD_BIT]) cnt_q <= intv_q;
    end else if (intv_we) begin
      intv_q <= wr_val;
      cnt_q  <= wr_val;
    end else if (run) begin
      cnt_q <= step_count(cnt_q, intv_q, ctrl_q[MODE_BIT]);
      if (at_one && ctrl_q[MODE_BIT]) ctrl_q[EN_BIT] <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;

  a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && ctrl_q[MODE_BIT] |=> !ctrl_q[EN_BIT] && at_zero);
  a_r7_periodic_runs: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !ctrl_q[MODE_BIT] |=> ctrl_q[EN_BIT]);
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    run && !at_zero |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we && !intv_we && !(tick_en && ctrl_q[EN_BIT]) |=> $stable(cnt_q));
  a_r3_interval_load: assert property (@(posedge clk) disable iff (!rst_n)
    intv_we && !ctrl_we |=> cnt_q == $past(wr_val) && intv_q == $past(wr_val));
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ien_we,
  input  logic           stat_we,
  input  logic [NCH-1:0] wmask,
  input  logic [NCH-1:0] expire_i,
  output logic [NCH-1:0] ien_o,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] ien_q, stat_q, irq_q, clr_vec;

  assign clr_vec = stat_we ? wmask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
      irq_q  <= '0;
    end else begin
      if (ien_we) ien_q <= wmask;
      stat_q <= (stat_q & ~clr_vec) | expire_i;
      irq_q  <= expire_i & ien_q;
    end
  end

  assign ien_o  = ien_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & $past(irq_q)) == '0);
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & ~$past(ien_q)) == '0);
  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i != '0 |=> (stat_q & $past(expire_i)) == $past(expire_i));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (stat_q & $past(wmask) & ~$past(expire_i)) == '0);
endmodule

// File: rtl/ivtimer_bank.sv
module ivtimer_bank
  import ivt_pkg::*;
#(
  parameter int unsigned NCH   = 6,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq_o
);
  localparam int unsigned IDX_W = 4;

  logic [7:0]       ctrl_a [NCH];
  logic [CNT_W-1:0] intv_a [NCH];
  logic [CNT_W-1:0] cnt_a  [NCH];
  logic [NCH-1:0]   ctrl_we, intv_we, expire, ien, stat;
  logic [IDX_W-1:0] slot, chan_idx;
  logic             chan_hit;
  sub_e             sub;
  logic [DW-1:0]    wd0_q, wd1_q;

  assign slot     = addr[7:4];
  assign chan_hit = (addr[AW-1:8] == '0) && (slot != '0) && (slot <= IDX_W'(NCH));
  assign chan_idx = slot - IDX_W'(1);
  assign sub      = decode_sub(addr[3:0]);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ctrl_we[n] = wr_en && chan_hit && (chan_idx == IDX_W'(n)) && (sub == SUB_CTRL);
    assign intv_we[n] = wr_en && chan_hit && (chan_idx == IDX_W'(n)) && (sub == SUB_INTV);
    ivt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .ctrl_we (ctrl_we[n]),
      .intv_we (intv_we[n]),
      .wr_val  (wdata[CNT_W-1:0]),
      .ctrl_o  (ctrl_a[n]),
      .intv_o  (intv_a[n]),
      .cnt_o   (cnt_a[n]),
      .expire_o(expire[n])
    );
  end

  ivt_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ien_we  (wr_en && addr == AW'(OFS_IEN)),
    .stat_we (wr_en && addr == AW'(OFS_STAT)),
    .wmask   (wdata[NCH-1:0]),
    .expire_i(expire),
    .ien_o   (ien),
    .stat_o  (stat),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd0_q <= '0;
      wd1_q <= '0;
    end else if (wr_en) begin
      if (addr == AW'(OFS_WD0)) wd0_q <= wdata;
      if (addr == AW'(OFS_WD1)) wd1_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_IEN))       rdata = DW'(ien);
    else if (addr == AW'(OFS_STAT)) rdata = DW'(stat);
    else if (addr == AW'(OFS_WD0))  rdata = wd0_q;
    else if (addr == AW'(OFS_WD1))  rdata = wd1_q;
    else if (chan_hit) begin
      for (int n = 0; n < NCH; n++) begin
        if (chan_idx == IDX_W'(n)) begin
          case (sub)
            SUB_CTRL: rdata = DW'(ctrl_a[n]);
            SUB_INTV: rdata = DW'(intv_a[n]);
            SUB_CNT:  rdata = DW'(cnt_a[n]);
            default:  rdata = '0;
          endcase
        end
      end
    end
  end

  a_r2_onehot_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, intv_we}));
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> irq_o == '0 && stat == '0);
endmodule

// File: tb/test_ivtimer_bank.sv
module test_ivtimer_bank;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_intv [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [5:0]  m_ien, m_stat, m_irq;
  logic [31:0] m_wd0, m_wd1;

  ivtimer_bank i_ivtimer_bank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  function automatic logic [9:0] ba(input int n);
    return 10'((n + 1) * 16);
  endfunction

  function automatic logic [31:0] m_read(input logic [9:0] a);
    if (a == 10'h000) return {26'd0, m_ien};
    if (a == 10'h004) return {26'd0, m_stat};
    if (a == 10'h090) return m_wd0;
    if (a == 10'h094) return m_wd1;
    for (int n = 0; n < NCH; n++) begin
      if (a == ba(n))         return {24'd0, m_ctrl[n]};
      if (a == ba(n) + 10'h4) return m_intv[n];
      if (a == ba(n) + 10'h8) return m_cnt[n];
    end
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < NCH; n++) begin
      m_ctrl[n] = 8'h04; m_intv[n] = '0; m_cnt[n] = '0;
    end
    m_ien = '0; m_stat = '0; m_irq = '0; m_wd0 = '0; m_wd1 = '0;
  endtask

  // One bus cycle: drive, check read, predict, clock, check pulses.
  task automatic cyc(input bit w, input logic [9:0] a, input logic [31:0] d,
                     input bit t, input string tag);
    logic [7:0]  n_ctrl [NCH];
    logic [31:0] n_intv [NCH];
    logic [31:0] n_cnt  [NCH];
    logic [5:0]  set_v, n_irq, n_stat, n_ien;
    wr_en = w; addr = a; wdata = d; tick_en = t;
    #1;
    check(tag, rdata, m_read(a));
    set_v = '0; n_irq = '0;
    for (int n = 0; n < NCH; n++) begin
      n_ctrl[n] = m_ctrl[n]; n_intv[n] = m_intv[n]; n_cnt[n] = m_cnt[n];
      if (w && a == ba(n)) begin
        n_ctrl[n] = d[7:0];
        if (d[1]) n_cnt[n] = m_intv[n];
      end else if (w && a == ba(n) + 10'h4) begin
        n_intv[n] = d; n_cnt[n] = d;
      end else if (t && m_ctrl[n][0]) begin
        if (m_cnt[n] == 32'd1) begin
          n_cnt[n] = 32'd0;
          set_v[n] = 1'b1;
          n_irq[n] = m_ien[n];
          if (m_ctrl[n][7]) n_ctrl[n][0] = 1'b0;
        end else if (m_cnt[n] == 32'd0) begin
          if (!m_ctrl[n][7]) n_cnt[n] = m_intv[n];
        end else begin
          n_cnt[n] = m_cnt[n] - 32'd1;
        end
      end
    end
    n_ien  = (w && a == 10'h000) ? d[5:0] : m_ien;
    n_stat = (m_stat & ~((w && a == 10'h004) ? d[5:0] : 6'd0)) | set_v;
    @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < NCH; n++) begin
      m_ctrl[n] = n_ctrl[n]; m_intv[n] = n_intv[n]; m_cnt[n] = n_cnt[n];
    end
    m_ien = n_ien; m_stat = n_stat; m_irq = n_irq;
    if (w && a == 10'h090) m_wd0 = d;
    if (w && a == 10'h094) m_wd1 = d;
    check({tag, " irq"}, {26'd0, irq_o}, {26'd0, m_irq});
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    cyc(1'b0, a, 32'd0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [9:0] pick [16];
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and of the pulses
    check("R1 irq", {26'd0, irq_o}, 32'd0);
    rd(10'h000, "R1 ien"); rd(10'h004, "R1 stat");
    for (int n = 0; n < NCH; n++) begin
      rd(ba(n), "R1 ctrl"); rd(ba(n) + 10'h4, "R1 intv"); rd(ba(n) + 10'h8, "R1 cnt");
    end
    check("R1 ctrl literal", m_read(ba(3)), 32'h04);

    // R2, R3: distinct intervals, readback and counter load; unmapped holes
    for (int n = 0; n < NCH; n++) cyc(1'b1, ba(n) + 10'h4, 32'h100 + 32'(n) * 32'h11, 1'b1, "R3 wr");
    for (int n = 0; n < NCH; n++) begin
      rd(ba(n) + 10'h4, "R2 intv"); rd(ba(n) + 10'h8, "R3 cnt");
    end
    rd(10'h01C, "R2 hole"); rd(10'h070, "R2 past last ch"); rd(10'h3F0, "R2 high");
    rd(10'h104, "R2 alias");

    // R4: control keeps only its low byte; reload copies interval
    cyc(1'b1, ba(4), 32'hABCD_008C, 1'b0, "R4 ctrl wr");
    rd(ba(4), "R4 ctrl mask");
    cyc(1'b1, ba(0) + 10'h4, 32'd20, 1'b0, "R4 setup");
    cyc(1'b1, ba(0), 32'h01, 1'b0, "R4 en");
    repeat (5) cyc(1'b0, ba(0) + 10'h8, 32'd0, 1'b1, "R5 count");
    cyc(1'b1, ba(0), 32'h03, 1'b1, "R4 reload");
    rd(ba(0) + 10'h8, "R4 reloaded");
    check("R4 literal", m_read(ba(0) + 10'h8), 32'd20);

    // R5: stopped channel holds, write beats tick
    cyc(1'b1, ba(0), 32'h00, 1'b1, "R5 stop");
    repeat (4) cyc(1'b0, ba(0) + 10'h8, 32'd0, 1'b1, "R5 hold");
    cyc(1'b1, ba(2), 32'h01, 1'b1, "R5 en ch2");
    cyc(1'b1, ba(2) + 10'h4, 32'd5, 1'b1, "R5 write wins");
    rd(ba(2) + 10'h8, "R5 no tick lost");

    // R6, R7, R9: periodic with interrupt enabled
    cyc(1'b1, 10'h000, 32'h01, 1'b0, "R9 ien");
    cyc(1'b1, ba(0) + 10'h4, 32'd2, 1'b0, "R7 intv");
    cyc(1'b1, ba(0), 32'h01, 1'b0, "R7 en");
    repeat (12) cyc(1'b0, ba(0) + 10'h8, 32'd0, 1'b1, "R7 periodic");
    rd(10'h004, "R6 stat");
    rd(ba(0), "R7 still on");

    // R6, R8, R9: one-shot on a channel whose interrupt is disabled
    cyc(1'b1, ba(1) + 10'h4, 32'd3, 1'b0, "R8 intv");
    cyc(1'b1, ba(1), 32'h81, 1'b0, "R8 en");
    repeat (7) cyc(1'b0, ba(1) + 10'h8, 32'd0, 1'b1, "R8 oneshot");
    rd(ba(1), "R8 enable dropped");
    check("R8 literal", m_read(ba(1)), 32'h80);
    check("R6 literal stat", {31'd0, m_stat[1]}, 32'd1);

    // R10: clear bits, then a clear colliding with an expiry
    cyc(1'b1, 10'h004, 32'h02, 1'b0, "R10 clr one");
    rd(10'h004, "R10 others kept");
    for (int k = 0; k < 20; k++) begin
      if (m_cnt[0] == 32'd1) cyc(1'b1, 10'h004, 32'h3F, 1'b1, "R10 set wins");
      else cyc(1'b0, 10'h004, 32'd0, 1'b1, "R10 run");
    end

    // R11: count writes and storage words change nothing else
    cyc(1'b1, ba(0), 32'h00, 1'b0, "R11 stop");
    cyc(1'b1, ba(0) + 10'h8, 32'hDEAD_BEEF, 1'b1, "R11 cnt wr");
    rd(ba(0) + 10'h8, "R11 cnt ignored");
    cyc(1'b1, 10'h090, 32'hCAFE_F00D, 1'b1, "R11 wd0");
    cyc(1'b1, 10'h094, 32'h1234_5678, 1'b1, "R11 wd1");
    rd(10'h090, "R11 wd0 rd"); rd(10'h094, "R11 wd1 rd");
    for (int n = 0; n < NCH; n++) rd(ba(n) + 10'h8, "R11 channels untouched");

    // Random phase
    pick[0] = 10'h000; pick[1] = 10'h004; pick[2] = 10'h090; pick[3] = 10'h094;
    pick[4] = 10'h3FC; pick[5] = 10'h01C;
    for (int n = 0; n < NCH; n++) pick[6 + n] = ba(n) + 10'h8;
    pick[12] = ba(1); pick[13] = ba(2) + 10'h4; pick[14] = ba(5); pick[15] = 10'h0A0;
    for (int k = 0; k < 4000; k++) begin
      int r, n;
      bit t;
      r = int'($urandom % 16);
      n = int'($urandom % NCH);
      t = ($urandom % 4) != 0;
      case (r)
        0, 1: cyc(1'b1, ba(n), {$urandom, 8'd0} | 32'(($urandom % 2) ? 8'h01 : 8'h00)
                  | 32'($urandom & 32'h8E), t, "R4 R5 rand ctrl");
        2:    cyc(1'b1, ba(n) + 10'h4, $urandom % 6, t, "R3 rand intv");
        3:    cyc(1'b1, 10'h004, $urandom, t, "R10 rand clr");
        4:    cyc(1'b1, 10'h000, $urandom, t, "R9 rand ien");
        5:    cyc(1'b1, ba(n) + 10'h8, $urandom, t, "R11 rand cnt");
        6:    cyc(1'b1, ($urandom % 2) ? 10'h090 : 10'h094, $urandom, t, "R11 rand wd");
        default: cyc(1'b0, pick[$urandom % 16], 32'd0, t, "R2 R6 rand read");
      endcase
    end
    finish_run();
  end
endmodule